// File: doc/BRIEF.md
# Tamper Pin Pair Checker

This block watches a group of tamper pins, which are organised in pairs. It has two ways of working. In static mode, each enabled pin is compared with a programmed active level. An alarm is raised while the pin sits at that level. In dynamic mode, the even pin of a pair drives a pseudo-random reference bit. The odd pin of the same pair must read that bit back. A disagreement means the loop between the two pads has been cut or forced.

The reference stream comes from a 32-bit word that rotates by one bit at every pattern update. The update period is selected by a rate code. Once all 32 bits of the word have been used, the block loads a new word. That word is either the next output of a maximal-length LFSR or a replay of the seed. A reload request restarts the whole generator from the seed. The reload also latches the rate code, the pattern-source choice and the seed. The block runs on the slow real-time clock. Every pin passes through a two-flop synchroniser, plus an optional extra debounce flop.

Top module: `tamper_pair_checker`

## Requirements
- R1: After reset, drive_out, pair_alarm, pin_alarm and reload_busy are all 0.
- R2: With latched rate code n, the driven pattern advances every 2^(6+n) clock cycles. The first advance comes 2^(6+n) cycles after the edge at which a reload is applied.
- R3: A change of rate_code has no effect on the update period until a reload is applied.
- R4: A request sampled at edge E sets reload_busy after E and keeps it set after E+1. The reload is applied at E+2, and reload_busy clears itself there. The reload restarts the period counter and the word, so drive_out[0] then shows seed bit 0.
- R5: With replay_seed=1, drive_out[0] after the j-th update equals seed bit (j mod 32). Pair k drives word bit k, and the word rotates right by one place per update.
- R6: With replay_seed=0, the first word after a reload is the seed. Each later word is the previous LFSR state advanced 32 steps. Each step is a right shift, followed by an XOR with 0x80200003 when the bit shifted out is 1. The LFSR state is never zero.
- R7: A seed of 0 is replaced by the constant 0xACE10001.
- R8: In dynamic mode, pair k compares odd pin 2k+1 (which must be enabled) against its reference bit once per update. A mismatch gives a one-cycle pair_alarm pulse, high in the cycle after edge T+4 for an update at edge T. A correct loopback gives no pulse.
- R9: When share_sel[k] is set, pair k (k ≥ 1) checks against pair 0's bit, but only if pair_dyn[0] and pair_dyn[k] are both set. Otherwise share_sel[k] is ignored.
- R10: A pin that is enabled and not in a dynamic pair raises pin_alarm while its synchronised value equals pin_level. The alarm appears 2 edges after a pin change or after enabling.
- R11: The pins of a pair with pair_dyn set never raise pin_alarm.
- R12: Setting pin_dbnc adds one edge of delay to both the static alarm and the dynamic comparison of that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 6 | Sampled pad values |
| pin_en | input | 6 | Per-pin detection enable |
| pin_level | input | 6 | Static active level per pin |
| pin_dbnc | input | 6 | Per-pin extra debounce stage |
| pair_dyn | input | 3 | Dynamic mode per pair |
| share_sel | input | 2 | Pairs 1..2 check against pair 0's bit |
| seed | input | 32 | Pattern seed |
| rate_code | input | 3 | Update period code |
| replay_seed | input | 1 | 1: replay seed, 0: next LFSR word |
| reload_req | input | 1 | Reload request pulse |
| drive_out | output | 3 | Reference bit driven on each pair's even pin |
| reload_busy | output | 1 | Reload in progress |
| pair_alarm | output | 3 | Per-pair mismatch pulse |
| pin_alarm | output | 6 | Per-pin static alarm |

## Verification
Each result is sampled at a known count of edges from the stimulus that caused it. The reload is applied two edges after the request edge. Pattern updates fall every 2^(6+n) edges after that. A pair alarm is due four edges after an update, or five with debounce. A static alarm is due two edges after a pin or enable change, or three with debounce. The bench drives inputs and samples outputs on the falling edge, and it counts whole rising edges from a reload. Every check therefore lands on the exact cycle a result is due, and also one cycle either side where that shows the timing.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int WORD_W     = 32;
    localparam int RATE_W     = 3;
    localparam int BASE_SHIFT = 6;

    localparam logic [WORD_W-1:0] LFSR_TAPS  = 32'h8020_0003;
    localparam logic [WORD_W-1:0] SEED_SUBST = 32'hACE1_0001;

    typedef enum logic [1:0] {
        RL_IDLE  = 2'd0,
        RL_SYNC  = 2'd1,
        RL_APPLY = 2'd2
    } reload_st_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              replay;
        logic [WORD_W-1:0] seed;
    } gen_cfg_t;

    function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

    function automatic logic [WORD_W-1:0] lfsr_word(input logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] v;
        v = s;
        for (int i = 0; i < WORD_W; i++) v = lfsr_step(v);
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] seed_fix(input logic [WORD_W-1:0] s);
        return (s == '0) ? SEED_SUBST : s;
    endfunction

endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
    parameter int NPINS       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_en,
    input  logic [NPINS-1:0] pin_dbnc,
    output logic [NPINS-1:0] pin_s,
    output logic [NPINS-1:0] en_ok
);
    logic [NPINS-1:0] chain_q [SYNC_STAGES+1];
    logic [NPINS-1:0] en_q    [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j <= SYNC_STAGES; j++) chain_q[j] <= '0;
            for (int j = 0; j < SYNC_STAGES; j++)  en_q[j]    <= '0;
        end else begin
            chain_q[0] <= pin_in;
            for (int j = 1; j <= SYNC_STAGES; j++) chain_q[j] <= chain_q[j-1];
            en_q[0] <= pin_en;
            for (int j = 1; j < SYNC_STAGES; j++)  en_q[j]    <= en_q[j-1];
        end
    end

    // the debounce flop is one stage beyond the normal synchroniser
    assign pin_s = (pin_dbnc & chain_q[SYNC_STAGES]) | (~pin_dbnc & chain_q[SYNC_STAGES-1]);
    assign en_ok = en_q[SYNC_STAGES-1];

endmodule

// File: rtl/tpc_pattern.sv
module tpc_pattern #(
    parameter int NPAIRS = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [tpc_pkg::WORD_W-1:0] seed,
    input  logic [tpc_pkg::RATE_W-1:0] rate_code,
    input  logic                       replay_seed,
    input  logic                       reload_req,
    output logic [NPAIRS-1:0]          drv_bits,
    output logic                       tick_o,
    output logic                       busy_o
);
    import tpc_pkg::*;

    localparam int CNT_W = BASE_SHIFT + (1 << RATE_W);
    localparam int IDX_W = $clog2(WORD_W);

    reload_st_e        st_q;
    gen_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  period_m1;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] lfsr_q;
    logic [WORD_W-1:0] lfsr_nxt;
    logic [WORD_W-1:0] seed_eff;

    assign period_m1 = (CNT_W'(1) << (BASE_SHIFT + int'(cfg_q.rate))) - CNT_W'(1);
    assign tick_o    = (cnt_q == period_m1) && (st_q != RL_APPLY);
    assign busy_o    = (st_q != RL_IDLE);
    assign lfsr_nxt  = lfsr_word(lfsr_q);
    assign seed_eff  = seed_fix(seed);
    assign drv_bits  = word_q[NPAIRS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RL_IDLE;
            cfg_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
            lfsr_q <= SEED_SUBST;
        end else begin
            unique case (st_q)
                RL_IDLE:  if (reload_req) st_q <= RL_SYNC;
                RL_SYNC:  st_q <= RL_APPLY;
                RL_APPLY: st_q <= RL_IDLE;
                default:  st_q <= RL_IDLE;
            endcase

            if (st_q == RL_APPLY) begin
                cfg_q.rate   <= rate_code;
                cfg_q.replay <= replay_seed;
                cfg_q.seed   <= seed_eff;
                word_q       <= seed_eff;
                lfsr_q       <= seed_eff;
                cnt_q        <= '0;
                idx_q        <= '0;
            end else begin
                cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
                if (tick_o) begin
                    if (idx_q == IDX_W'(WORD_W-1)) begin
                        idx_q  <= '0;
                        lfsr_q <= lfsr_nxt;
                        word_q <= cfg_q.replay ? cfg_q.seed : lfsr_nxt;
                    end else begin
                        idx_q  <= idx_q + IDX_W'(1);
                        word_q <= {word_q[0], word_q[WORD_W-1:1]};
                    end
                end
            end
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R4
    reload_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |=> !busy_o);

    // R6
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/tpc_pair_cmp.sv
module tpc_pair_cmp #(
    parameter int NPAIRS      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NPAIRS-1:0] drv_bits,
    input  logic [NPAIRS-1:0] pair_dyn,
    input  logic [NPAIRS-1:1] share_sel,
    input  logic [NPAIRS-1:0] chk_pin,
    input  logic [NPAIRS-1:0] chk_en,
    input  logic [NPAIRS-1:0] chk_dbnc,
    output logic [NPAIRS-1:0] alarm_o
);
    localparam int TK_LEN  = SYNC_STAGES + 3;
    localparam int TK_FAST = SYNC_STAGES + 1;
    localparam int TK_SLOW = SYNC_STAGES + 2;

    logic [TK_LEN-1:0] tk_q;
    logic [NPAIRS-1:0] ref_bit;
    logic [NPAIRS-1:0] strobe;
    logic [NPAIRS-1:0] miss;
    logic [NPAIRS-1:0] alarm_q;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
        if (k == 0) begin : g_base
            assign ref_bit[k] = drv_bits[0];
        end else begin : g_shared
            assign ref_bit[k] = (share_sel[k] & pair_dyn[0] & pair_dyn[k]) ? drv_bits[0]
                                                                            : drv_bits[k];
        end
        // one spare cycle for the pad round trip, then the synchroniser depth
        assign strobe[k] = chk_dbnc[k] ? tk_q[TK_SLOW] : tk_q[TK_FAST];
        assign miss[k]   = pair_dyn[k] & chk_en[k] & strobe[k] & (chk_pin[k] != ref_bit[k]);

        // R8
        alarm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            alarm_q[k] |=> !alarm_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tk_q    <= '0;
            alarm_q <= '0;
        end else begin
            tk_q    <= {tk_q[TK_LEN-2:0], tick};
            alarm_q <= miss;
        end
    end

    assign alarm_o = alarm_q;

endmodule

// File: rtl/tpc_static.sv
module tpc_static #(
    parameter int NPAIRS = 3,
    localparam int NPINS = 2 * NPAIRS
) (
    input  logic [NPINS-1:0]  pin_s,
    input  logic [NPINS-1:0]  en_ok,
    input  logic [NPINS-1:0]  pin_level,
    input  logic [NPAIRS-1:0] pair_dyn,
    output logic [NPINS-1:0]  alarm_o
);
    logic [NPINS-1:0] dyn_mask;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_mask
        assign dyn_mask[2*k]   = pair_dyn[k];
        assign dyn_mask[2*k+1] = pair_dyn[k];
    end

    assign alarm_o = en_ok & ~dyn_mask & ~(pin_s ^ pin_level);

endmodule

// File: rtl/tamper_pair_checker.sv
module tamper_pair_checker #(
    parameter int NPAIRS      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NPINS      = 2 * NPAIRS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPINS-1:0]           pin_in,
    input  logic [NPINS-1:0]           pin_en,
    input  logic [NPINS-1:0]           pin_level,
    input  logic [NPINS-1:0]           pin_dbnc,
    input  logic [NPAIRS-1:0]          pair_dyn,
    input  logic [NPAIRS-1:1]          share_sel,
    input  logic [tpc_pkg::WORD_W-1:0] seed,
    input  logic [tpc_pkg::RATE_W-1:0] rate_code,
    input  logic                       replay_seed,
    input  logic                       reload_req,
    output logic [NPAIRS-1:0]          drive_out,
    output logic                       reload_busy,
    output logic [NPAIRS-1:0]          pair_alarm,
    output logic [NPINS-1:0]           pin_alarm
);
    logic [NPINS-1:0]  pin_s;
    logic [NPINS-1:0]  en_ok;
    logic [NPAIRS-1:0] drv_bits;
    logic              tick;
    logic [NPAIRS-1:0] chk_pin;
    logic [NPAIRS-1:0] chk_en;
    logic [NPAIRS-1:0] chk_dbnc;

    tpc_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_en(pin_en),
        .pin_dbnc(pin_dbnc), .pin_s(pin_s), .en_ok(en_ok)
    );

    tpc_pattern #(.NPAIRS(NPAIRS)) u_pattern (
        .clk(clk), .rst(rst), .seed(seed), .rate_code(rate_code),
        .replay_seed(replay_seed), .reload_req(reload_req),
        .drv_bits(drv_bits), .tick_o(tick), .busy_o(reload_busy)
    );

    for (genvar k = 0; k < NPAIRS; k++) begin : g_odd
        assign chk_pin[k]  = pin_s[2*k+1];
        assign chk_en[k]   = en_ok[2*k+1];
        assign chk_dbnc[k] = pin_dbnc[2*k+1];
    end

    tpc_pair_cmp #(.NPAIRS(NPAIRS), .SYNC_STAGES(SYNC_STAGES)) u_cmp (
        .clk(clk), .rst(rst), .tick(tick), .drv_bits(drv_bits),
        .pair_dyn(pair_dyn), .share_sel(share_sel), .chk_pin(chk_pin),
        .chk_en(chk_en), .chk_dbnc(chk_dbnc), .alarm_o(pair_alarm)
    );

    tpc_static #(.NPAIRS(NPAIRS)) u_static (
        .pin_s(pin_s), .en_ok(en_ok), .pin_level(pin_level),
        .pair_dyn(pair_dyn), .alarm_o(pin_alarm)
    );

    assign drive_out = drv_bits & pair_dyn;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_quiet
        // R11
        dyn_static_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            pair_dyn[k] |-> (pin_alarm[2*k] == 1'b0 && pin_alarm[2*k+1] == 1'b0));
    end

endmodule

// File: tb/tb_tamper_pair_checker.sv
module tb_tamper_pair_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pin_in, pin_en, pin_level, pin_dbnc, st_pin;
    logic [2:0]  pair_dyn, lb_on, lb_from0, lb_inv;
    logic [2:1]  share_sel;
    logic [31:0] seed;
    logic [2:0]  rate_code;
    logic        replay_seed, reload_req;
    logic [2:0]  drive_out, pair_alarm;
    logic        reload_busy;
    logic [5:0]  pin_alarm;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            pin_in[2*k]   = st_pin[2*k];
            pin_in[2*k+1] = lb_on[k] ? ((lb_from0[k] ? drive_out[0] : drive_out[k]) ^ lb_inv[k])
                                     : st_pin[2*k+1];
        end
    end

    tamper_pair_checker dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_en(pin_en), .pin_level(pin_level),
        .pin_dbnc(pin_dbnc), .pair_dyn(pair_dyn), .share_sel(share_sel), .seed(seed),
        .rate_code(rate_code), .replay_seed(replay_seed), .reload_req(reload_req),
        .drive_out(drive_out), .reload_busy(reload_busy), .pair_alarm(pair_alarm),
        .pin_alarm(pin_alarm)
    );

    function automatic logic [31:0] ref_word(input logic [31:0] s);
        logic [31:0] v;
        v = s;
        for (int i = 0; i < 32; i++) v = v[0] ? ((v >> 1) ^ 32'h8020_0003) : (v >> 1);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cfg();
        pin_en = '0; pin_level = '0; pin_dbnc = '0; st_pin = '0;
        pair_dyn = '0; lb_on = '0; lb_from0 = '0; lb_inv = '0; share_sel = '0;
        seed = 32'h5555_5555; rate_code = '0; replay_seed = 1'b1; reload_req = 1'b0;
        step(8);
    endtask

    // leaves the bench just after the edge at which the reload is applied
    task automatic do_reload();
        reload_req = 1'b1;
        step(1);
        reload_req = 1'b0;
        step(2);
    endtask

    task automatic count_alarm(input int k, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (pair_alarm[k]) c++;
        end
    endtask

    task automatic t_reset();
        chk("R1 drive_out", 32'(drive_out), 0);
        chk("R1 pair_alarm", 32'(pair_alarm), 0);
        chk("R1 pin_alarm", 32'(pin_alarm), 0);
        chk("R1 reload_busy", 32'(reload_busy), 0);
    endtask

    task automatic t_reload();
        clear_cfg();
        pair_dyn = 3'b001;
        reload_req = 1'b1;
        step(1);
        reload_req = 1'b0;
        chk("R4 busy after request edge", 32'(reload_busy), 1);
        step(1);
        chk("R4 busy one edge later", 32'(reload_busy), 1);
        step(1);
        chk("R4 busy self-clears", 32'(reload_busy), 0);
        chk("R4 seed bit0 driven", 32'(drive_out[0]), 1);
        step(30);
        do_reload();
        step(63);
        chk("R4 counter restarted (no update yet)", 32'(drive_out[0]), 1);
        step(1);
        chk("R4 counter restarted (update)", 32'(drive_out[0]), 0);
    endtask

    task automatic t_rate(input logic [2:0] n);
        int p;
        p = 1 << (6 + n);
        clear_cfg();
        pair_dyn = 3'b001;
        rate_code = n;
        do_reload();
        step(p - 1);
        chk($sformatf("R2 rate %0d before update", n), 32'(drive_out[0]), 1);
        step(1);
        chk($sformatf("R2 rate %0d at update", n), 32'(drive_out[0]), 0);
        step(p);
        chk($sformatf("R2 rate %0d second update", n), 32'(drive_out[0]), 1);
    endtask

    task automatic t_rate_hold();
        clear_cfg();
        pair_dyn = 3'b001;
        rate_code = 3'd1;
        do_reload();
        rate_code = 3'd0;
        step(64);
        chk("R3 new rate ignored without reload", 32'(drive_out[0]), 1);
        step(64);
        chk("R3 old period kept", 32'(drive_out[0]), 0);
        do_reload();
        step(63);
        chk("R3 new rate after reload (before)", 32'(drive_out[0]), 1);
        step(1);
        chk("R3 new rate after reload (update)", 32'(drive_out[0]), 0);
    endtask

    task automatic t_pattern(input logic [31:0] s, input logic rep);
        logic [31:0] got0, got1, exp1, exp0;
        clear_cfg();
        pair_dyn = 3'b001;
        seed = s;
        replay_seed = rep;
        do_reload();
        for (int j = 0; j < 64; j++) begin
            if (j < 32) got0[j] = drive_out[0];
            else        got1[j-32] = drive_out[0];
            step(64);
        end
        exp0 = (s == 0) ? 32'hACE1_0001 : s;
        exp1 = rep ? exp0 : ref_word(exp0);
        if (s == 0) begin
            chk("R7 zero seed substitute word", got0, exp0);
            chk("R7 zero seed replayed word", got1, exp1);
        end else if (rep) begin
            chk("R5 first word equals seed", got0, exp0);
            chk("R5 replayed word equals seed", got1, exp1);
        end else begin
            chk("R6 first word equals seed", got0, exp0);
            chk("R6 next word from LFSR", got1, exp1);
        end
    endtask

    task automatic t_pair();
        int c;
        clear_cfg();
        pair_dyn = 3'b111;
        pin_en = 6'h3F;
        lb_on = 3'b111;
        do_reload();
        count_alarm(0, 200, c);
        chk("R8 loopback gives no alarm", 32'(c), 0);
        do_reload();
        lb_inv = 3'b111;
        step(67);
        chk("R8 no alarm before due cycle", 32'(pair_alarm), 0);
        step(1);
        chk("R8 alarm on all pairs at T+4", 32'(pair_alarm), 32'h7);
        step(1);
        chk("R8 alarm lasts one cycle", 32'(pair_alarm), 0);
        lb_inv = 3'b000;
        pin_dbnc[1] = 1'b1;
        step(8);
        do_reload();
        lb_inv = 3'b111;
        step(68);
        chk("R12 debounced pair late at T+4", 32'(pair_alarm), 32'h6);
        step(1);
        chk("R12 debounced pair alarm at T+5", 32'(pair_alarm), 32'h1);
        count_alarm(0, 192, c);
        chk("R8 one pulse per update", 32'(c), 3);
    endtask

    task automatic t_share();
        int c;
        clear_cfg();
        pair_dyn = 3'b011;
        pin_en = 6'h3F;
        share_sel = 2'b01;
        lb_on = 3'b011;
        lb_from0 = 3'b010;
        do_reload();
        count_alarm(1, 192, c);
        chk("R9 shared pair checks pair 0 bit", 32'(c), 0);
        lb_from0 = 3'b000;
        step(8);
        count_alarm(1, 192, c);
        chk("R9 shared pair flags own bit", 32'(c), 3);
        pair_dyn = 3'b010;
        step(8);
        count_alarm(1, 192, c);
        chk("R9 select ignored without pair 0 dynamic", 32'(c), 0);
    endtask

    task automatic t_static();
        clear_cfg();
        pin_level[2] = 1'b1; pin_en[2] = 1'b1;
        step(3);
        chk("R10 no alarm off level", 32'(pin_alarm[2]), 0);
        st_pin[2] = 1'b1;
        step(1);
        chk("R10 high level not yet", 32'(pin_alarm[2]), 0);
        step(1);
        chk("R10 high level after 2 edges", 32'(pin_alarm[2]), 1);
        st_pin[4] = 1'b1; pin_level[4] = 1'b0; pin_en[4] = 1'b1;
        step(3);
        chk("R10 low level idle", 32'(pin_alarm[4]), 0);
        st_pin[4] = 1'b0;
        step(2);
        chk("R10 low level alarm", 32'(pin_alarm[4]), 1);
        st_pin[5] = 1'b1; pin_level[5] = 1'b1;
        step(3);
        chk("R10 disabled pin quiet", 32'(pin_alarm[5]), 0);
        pin_en[5] = 1'b1;
        step(1);
        chk("R10 enable not yet", 32'(pin_alarm[5]), 0);
        step(1);
        chk("R10 enable after 2 edges", 32'(pin_alarm[5]), 1);
        pin_dbnc[0] = 1'b1; pin_level[0] = 1'b1; pin_en[0] = 1'b1;
        step(4);
        st_pin[0] = 1'b1;
        step(2);
        chk("R12 debounced static not at 2 edges", 32'(pin_alarm[0]), 0);
        step(1);
        chk("R12 debounced static at 3 edges", 32'(pin_alarm[0]), 1);
        pair_dyn[1] = 1'b1;
        step(1);
        chk("R11 dynamic pair pins quiet", 32'(pin_alarm[3:2]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        pin_en = '0; pin_level = '0; pin_dbnc = '0; st_pin = '0;
        pair_dyn = 3'b111; lb_on = '0; lb_from0 = '0; lb_inv = '0; share_sel = '0;
        seed = '0; rate_code = '0; replay_seed = 1'b0; reload_req = 1'b0;
        step(5);
        rst = 1'b0;
        step(1);
        t_reset();
        t_reload();
        t_rate(3'd0);
        t_rate(3'd3);
        t_rate(3'd7);
        t_rate_hold();
        t_pattern(32'h1234_ABCD, 1'b1);
        t_pattern(32'h1234_ABCD, 1'b0);
        t_pattern(32'h0000_0000, 1'b1);
        t_pair();
        t_share();
        t_static();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule